// File: doc/BRIEF.md
# Packed-Nibble DES Substitution Unit

This unit performs the substitution step of a DES-style round. It accepts a 48-bit word that has already been expanded and mixed with the round key. It returns the 32-bit output of the eight 6-to-4 substitution boxes. The eight boxes are not built as separate lookup tables. Their 512 four-bit entries are packed two per byte into one 256 x 8 table, so the same byte-wide lookup can also serve other byte substitutions.

The 48-bit word splits into eight 6-bit groups. For each group, the unit works out a byte address in the packed table and whether the wanted entry sits in the upper or the lower half of that byte. The groups go through one synchronous read port, one per cycle. Each returned nibble is placed in its slot of the 32-bit result. A start pulse launches a pass. Done pulses when all eight nibbles are in place. The result then holds until the next pass writes over it.

Top module: `sbox_packed_sub`

## Requirements
- R1: Box b (0..7) entry i (0..63) sits in table byte b*32 + i/2. An even i is held in bits [7:4] and an odd i in bits [3:0]. Box 0 entries 0 and 1 are 14 and 4, so byte 0 holds 0xE4.
- R2: Group g covers input bits [47-6g : 42-6g], and g = 0 is the most significant group. Its box-g result goes to output bits [31-4g : 28-4g].
- R3: Inside a 6-bit group b5..b0, the row is {b5,b0} and the column is b4..b1. The in-box entry index is row*16 + column.
- R4: While busy_o is low, a start_i sampled high captures din_i, and busy_o is high from the next cycle.
- R5: A start_i sampled while busy_o is high is ignored. The running pass finishes with the word it captured, and no extra pass follows.
- R6: done_o is high for exactly one cycle, 9 cycles after the accepting start edge. busy_o falls at that same edge, and dout_o then holds the full substitution of the captured word.
- R7: While busy_o is low, dout_o does not change.
- R8: While reset is active and after it is released, busy_o and done_o are low until a start is accepted. Reset is asynchronous and active-low, and its release is synchronised internally over two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that launches a pass when idle |
| din_i | input | 48 | Expanded, key-mixed word |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | One-cycle pulse: dout_o is complete |
| dout_o | output | 32 | Substitution result |

## Verification
The bench feeds an all-zero word and an all-one word, which hit the first and last entry of every box. It also uses per-group patterns that pick odd indices. An address that drops the box offset, or a swapped upper/lower nibble choice, would then return the wrong neighbour's value. A row/column swap and a reversed group order both show up as nibbles that land in the wrong place or take wrong values. A start pulse in the middle of a pass checks that the captured word is not overwritten and that no second pass appears. A cycle-exact model catches done arriving one cycle early or late, or lasting more than one cycle.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
  localparam int unsigned GROUPS  = 8;
  localparam int unsigned GRP_W   = 6;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned ENT_N   = 1 << GRP_W;
  localparam int unsigned IN_W    = GROUPS * GRP_W;
  localparam int unsigned OUT_W   = GROUPS * NIB_W;
  localparam int unsigned GIDX_W  = $clog2(GROUPS);
  localparam int unsigned ADDR_W  = GIDX_W + GRP_W - 1;
  localparam int unsigned BYTE_W  = 2 * NIB_W;
  localparam int unsigned BOX_BITS = ENT_N * NIB_W;

  // Each box: 64 nibbles, entry 0 in the top nibble.
  localparam logic [BOX_BITS-1:0] BOX_TBL [GROUPS] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
  };

  function automatic logic [NIB_W-1:0] box_entry(input logic [GIDX_W-1:0] box,
                                                  input logic [GRP_W-1:0]  idx);
    logic [BOX_BITS-1:0] row_bits;
    row_bits  = BOX_TBL[box];
    box_entry = row_bits[BOX_BITS-1 - NIB_W*int'(idx) -: NIB_W];
  endfunction

  // Packed byte: box in the top address bits, pair index below.
  function automatic logic [BYTE_W-1:0] pack_byte(input logic [ADDR_W-1:0] addr);
    logic [GIDX_W-1:0] box;
    logic [GRP_W-1:0]  even_idx;
    box       = addr[ADDR_W-1 -: GIDX_W];
    even_idx  = {addr[GRP_W-2:0], 1'b0};
    pack_byte = {box_entry(box, even_idx), box_entry(box, even_idx | 6'd1)};
  endfunction
endpackage

// File: rtl/sbox_rst_sync.sv
module sbox_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/sbox_addr_gen.sv
module sbox_addr_gen
  import sbox_pkg::*;
(
  input  logic [GRP_W-1:0]  grp_i,
  input  logic [GIDX_W-1:0] gidx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              lo_sel_o
);
  logic [GRP_W-1:0] idx;

  // Row from the outer bits, column from the inner four.
  always_comb begin
    idx      = {grp_i[GRP_W-1], grp_i[0], grp_i[GRP_W-2:1]};
    addr_o   = {gidx_i, idx[GRP_W-1:1]};
    lo_sel_o = idx[0];
  end
endmodule

// File: rtl/sbox_pack_rom.sv
module sbox_pack_rom
  import sbox_pkg::*;
(
  input  logic              clk,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rd_en_i) rdata_q <= pack_byte(addr_i);
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sbox_packed_sub.sv
module sbox_packed_sub
  import sbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IN_W-1:0]  din_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [OUT_W-1:0] dout_o
);
  localparam int unsigned PH_W = $clog2(GROUPS + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(GROUPS);

  logic rst_q_n;

  logic             busy_q, busy_d;
  logic [PH_W-1:0]  phase_q, phase_d;
  logic [IN_W-1:0]  word_q, word_d;
  logic             sel_q, sel_d;
  logic             done_q, done_d;
  logic [OUT_W-1:0] res_q, res_d;

  logic              issue, collect, accept;
  logic [GIDX_W-1:0] rd_gidx, wr_gidx;
  logic [GRP_W-1:0]  grp;
  logic [ADDR_W-1:0] rd_addr;
  logic              lo_sel;
  logic [BYTE_W-1:0] rd_byte;
  logic [NIB_W-1:0]  nib;

  sbox_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  assign accept  = start_i && !busy_q;
  assign issue   = busy_q && (phase_q < PH_LAST);
  assign collect = busy_q && (phase_q != '0);
  assign rd_gidx = phase_q[GIDX_W-1:0];
  assign wr_gidx = GIDX_W'(phase_q - PH_W'(1));

  always_comb begin
    grp = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (rd_gidx == GIDX_W'(g)) grp = word_q[IN_W-1 - GRP_W*g -: GRP_W];
    end
  end

  sbox_addr_gen u_addr (
    .grp_i(grp), .gidx_i(rd_gidx), .addr_o(rd_addr), .lo_sel_o(lo_sel)
  );

  sbox_pack_rom u_rom (
    .clk(clk), .rd_en_i(issue), .addr_i(rd_addr), .rdata_o(rd_byte)
  );

  assign nib = sel_q ? rd_byte[NIB_W-1:0] : rd_byte[BYTE_W-1:NIB_W];

  // Next state
  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    word_d  = word_q;
    sel_d   = sel_q;
    done_d  = 1'b0;
    res_d   = res_q;
    if (accept) begin
      busy_d  = 1'b1;
      phase_d = '0;
      word_d  = din_i;
    end else if (busy_q) begin
      phase_d = phase_q + PH_W'(1);
      if (issue) sel_d = lo_sel;
      if (collect) begin
        for (int g = 0; g < GROUPS; g++) begin
          if (wr_gidx == GIDX_W'(g)) res_d[OUT_W-1 - NIB_W*g -: NIB_W] = nib;
        end
      end
      if (phase_q == PH_LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      word_q <= '0;
      sel_q  <= 1'b0;
      res_q  <= '0;
    end else begin
      if (accept)  word_q <= word_d;
      if (issue)   sel_q  <= sel_d;
      if (collect) res_q  <= res_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign dout_o = res_q;
endmodule

// File: rtl/sbox_packed_sub_chk.sv
module sbox_packed_sub_chk
  import sbox_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [OUT_W-1:0] dout_o
);
  localparam int unsigned LAT = GROUPS + 1;
  localparam int unsigned LC_W = $clog2(LAT + 2);

  logic [LC_W-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  lat_q <= '0;
    else if (start_i && !busy_o) lat_q <= '0;
    else if (busy_o)             lat_q <= lat_q + LC_W'(1);
  end

  // R4
  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  // R5: busy only ends with completion
  a_r5_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  // R6
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_q == LC_W'(LAT)));
  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(dout_o));
  // R8
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

bind sbox_packed_sub sbox_packed_sub_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .dout_o(dout_o)
);

// File: tb/sbox_packed_sub_tb.sv
module sbox_packed_sub_tb;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [47:0] din_i;
  logic        busy_o;
  logic        done_o;
  logic [31:0] dout_o;

  int checks = 0;
  int fails  = 0;

  // Reference: eight unpacked boxes of 64 entries (row-major, 16 per row)
  logic [255:0] boxes [8] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
  };
  int ref_tbl [8][64];

  sbox_packed_sub u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .din_i(din_i),
    .busy_o(busy_o), .done_o(done_o), .dout_o(dout_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] ref_sub(input logic [47:0] w);
    logic [31:0] r;
    r = '0;
    for (int g = 0; g < 8; g++) begin
      int b, row, col;
      b   = int'(w[47-6*g -: 6]);
      row = ((b >> 5) & 1) * 2 + (b & 1);
      col = (b >> 1) & 15;
      r[31-4*g -: 4] = 4'(ref_tbl[g][row*16 + col]);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Cycle-level behavioural model
  bit          m_busy = 0;
  bit          m_done = 0;
  int          m_cnt  = 0;
  logic [31:0] m_exp  = '0;
  logic [31:0] m_out  = '0;
  bit          m_on   = 0;
  int          passes = 0;

  always @(posedge clk) begin
    if (m_on) begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 9) begin
          m_busy = 0; m_done = 1; m_out = m_exp; passes++;
        end
      end else if (start_i) begin
        m_busy = 1; m_cnt = 0; m_exp = ref_sub(din_i);
      end
    end
  end

  // Every-clock comparison away from the edge
  always @(negedge clk) begin
    if (m_on) begin
      chk("R4/R5 busy", 32'(busy_o), 32'(m_busy));
      chk("R6 done",    32'(done_o), 32'(m_done));
      if (m_done || !m_busy) chk("R6/R7 dout", dout_o, m_out);
    end
  end

  task automatic run_word(input logic [47:0] w, input string tag);
    @(negedge clk);
    start_i = 1'b1; din_i = w;
    @(negedge clk);
    start_i = 1'b0; din_i = '0;
    repeat (9) @(negedge clk);
    chk(tag, dout_o, ref_sub(w));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    automatic logic [47:0] w;
    for (int b = 0; b < 8; b++)
      for (int i = 0; i < 64; i++)
        ref_tbl[b][i] = int'(boxes[b][255-4*i -: 4]);

    start_i = 1'b0; din_i = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: outputs idle in reset
    chk("R8 busy in reset", 32'(busy_o), 32'h0);
    chk("R8 done in reset", 32'(done_o), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 busy after reset", 32'(busy_o), 32'h0);
    m_on = 1;

    // R1: index 0 of every box (upper nibble of each box's first byte)
    run_word(48'h0, "R1 all-zero");
    chk("R1 byte0 upper nibble E", {28'h0, dout_o[31:28]}, 32'hE);
    // R1 odd index 1: group 0 = 000010, rest zero -> lower nibble 4
    run_word({6'b000010, 42'h0}, "R1 odd index");
    chk("R1 byte0 lower nibble 4", {28'h0, dout_o[31:28]}, 32'h4);
    // R3: last entry (row 3, col 15) of every box
    run_word({48{1'b1}}, "R3 all-one");
    // R3: row bits only (b5,b0) in every group -> column 0, row 3
    run_word({8{6'b100001}}, "R3 row-only");
    // R3: column bits only -> row 0 col 15 (odd index)
    run_word({8{6'b011110}}, "R3 col-only");
    // R2: distinct group in each position
    for (int g = 0; g < 8; g++) begin
      w = '0;
      w[47-6*g -: 6] = 6'(7 * g + 5);
      run_word(w, "R2 group position");
    end
    // R2/R3 random words
    for (int k = 0; k < 40; k++) begin
      w = {$urandom, $urandom};
      run_word(w, "R2 random");
    end

    // R5: start while busy ignored
    begin
      automatic logic [47:0] w1 = 48'h123456789ABC;
      automatic int p0;
      @(negedge clk);
      start_i = 1'b1; din_i = w1;
      @(negedge clk);
      din_i = 48'hFEDCBA987654;     // start held high while busy
      repeat (4) @(negedge clk);
      start_i = 1'b0;
      repeat (5) @(negedge clk);
      p0 = passes;
      chk("R5 first word kept", dout_o, ref_sub(w1));
      repeat (12) @(negedge clk);
      chk("R5 no extra pass", 32'(passes), 32'(p0));
      chk("R7 hold idle", dout_o, ref_sub(w1));
    end

    // R4/R6: back-to-back starts at the earliest idle cycle
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      start_i = 1'b1; din_i = {$urandom, $urandom};
      @(negedge clk);
      start_i = 1'b0;
      repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    m_on = 0;
    chk("R6 pass count sane", 32'(passes > 50), 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule